// File: doc/BRIEF.md
# Codec Control-Port Serial Writer

This block writes configuration registers of an audio codec over a three-wire, write-only control port. A requester presents a 7-bit register address and a 9-bit value on a valid/ready handshake. The block packs them into one 16-bit frame and shifts it out most significant bit first. The frame is framed by an active-low select, and a direction line is held high for the whole transfer. Every pin change is followed by a settle interval of a programmable number of clock cycles, so the port runs at a bit rate the codec accepts whatever the system clock rate is.

The codec has no read path, so the block keeps a local shadow copy of each register it has written. A combinational read port returns the shadowed value of any address. A request can carry a no-cache flag. The frame is then sent as usual and the shadow copy is left unchanged. This is useful for update strobes that must not replace the stored setting.

Top module: `codec_ctl_writer`

## Requirements
- R1: After reset, sel_n is high, ser_clk is high, dir_wr is low, req_ready is high and every shadow entry reads 0.
- R2: The frame is {addr[6:0], data[8:0]}: 16 bits, most significant bit first, each bit valid on a rising ser_clk edge while sel_n is low.
- R3: In the clock edge that accepts a request, sel_n goes low and dir_wr goes high. ser_clk first falls one step (STEP_CYCLES clocks) later.
- R4: Each bit takes three steps: ser_clk low, then ser_dat set to the bit, then ser_clk high. ser_dat changes only while ser_clk is low, so ser_clk stays low for two steps per bit.
- R5: After the last bit, ser_clk falls and sel_n rises in the same cycle, 49 steps after acceptance. One step later ser_clk rises once more with sel_n high.
- R6: req_ready is low from the cycle after acceptance until 51 steps after acceptance, and is high again from then on.
- R7: A request accepted with req_nocache low stores its data in the shadow entry for its address. The new value is visible on rd_data in the next cycle.
- R8: A request accepted with req_nocache high sends its frame but leaves the shadow copy unchanged.
- R9: rd_data always shows the shadow entry selected by rd_addr, combinationally, for all 128 addresses.
- R10: req_valid raised while req_ready is low has no effect on the frame in flight or on the shadow copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 7 | Codec register address |
| req_data | input | 9 | Value to write |
| req_nocache | input | 1 | Send the frame without updating the shadow copy |
| rd_addr | input | 7 | Shadow read address |
| rd_data | output | 9 | Shadowed value at rd_addr |
| ser_clk | output | 1 | Serial clock to the codec |
| ser_dat | output | 1 | Serial data to the codec |
| sel_n | output | 1 | Active-low chip select |
| dir_wr | output | 1 | Write-direction line, high during a transfer |

## Verification
Every one of the 128 addresses is written once with an address-dependent value. This separates address bits from data bits in the decoded frame and shows aliasing in the shadow file. All-zero and all-ones data values at the extreme addresses show whether bits are stuck or shifted at either end of the frame. No-cache writes and requests raised while busy go to addresses with known shadow contents, so a stray update shows up on readback. The time from acceptance to each control edge is measured in whole steps for every frame, which exposes a missing or extra settle step at any phase.

// File: rtl/codec_ctl_pkg.sv
package codec_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_CLK_LO,
    ST_DATA,
    ST_CLK_HI,
    ST_END_LO,
    ST_END_HI
  } seq_state_t;
endpackage

// File: rtl/ccw_step_timer.sv
module ccw_step_timer #(
  parameter int STEP_CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic step_done
);
  localparam int CNT_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign step_done = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)        cnt_d = '0;
    else if (step_done) cnt_d = '0;
    else if (run)       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ccw_sequencer.sv
module ccw_sequencer
  import codec_ctl_pkg::*;
#(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic               step_done,
  output logic               busy,
  output logic               sclk,
  output logic               sdo,
  output logic               csn,
  output logic               rw
);
  localparam int IDX_W = $clog2(FRAME_W);
  localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(FRAME_W - 1);

  seq_state_t         st_q, st_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic sclk_q, sclk_d, sdo_q, sdo_d, csn_q, csn_d, rw_q, rw_d;

  always_comb begin
    st_d = st_q; sh_d = sh_q; idx_d = idx_q;
    sclk_d = sclk_q; sdo_d = sdo_q; csn_d = csn_q; rw_d = rw_q;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_d = ST_START; sh_d = frame_in; idx_d = '0;
        csn_d = 1'b0; rw_d = 1'b1;
      end
      ST_START: if (step_done) begin
        st_d = ST_CLK_LO; sclk_d = 1'b0;
      end
      ST_CLK_LO: if (step_done) begin
        st_d = ST_DATA; sdo_d = sh_q[FRAME_W-1];
      end
      ST_DATA: if (step_done) begin
        st_d = ST_CLK_HI; sclk_d = 1'b1;
      end
      ST_CLK_HI: if (step_done) begin
        sclk_d = 1'b0;
        if (idx_q == LAST_BIT) begin
          st_d = ST_END_LO; csn_d = 1'b1;
        end else begin
          st_d = ST_CLK_LO;
          sh_d = {sh_q[FRAME_W-2:0], 1'b0};
          idx_d = idx_q + 1'b1;
        end
      end
      ST_END_LO: if (step_done) begin
        st_d = ST_END_HI; sclk_d = 1'b1;
      end
      ST_END_HI: if (step_done) begin
        st_d = ST_IDLE; rw_d = 1'b0;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; sh_q <= '0; idx_q <= '0;
      sclk_q <= 1'b1; sdo_q <= 1'b0; csn_q <= 1'b1; rw_q <= 1'b0;
    end else begin
      st_q <= st_d; sh_q <= sh_d; idx_q <= idx_d;
      sclk_q <= sclk_d; sdo_q <= sdo_d; csn_q <= csn_d; rw_q <= rw_d;
    end
  end

  assign busy = (st_q != ST_IDLE);
  assign sclk = sclk_q;
  assign sdo  = sdo_q;
  assign csn  = csn_q;
  assign rw   = rw_q;
endmodule

// File: rtl/ccw_shadow.sv
module ccw_shadow #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] ent_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic ent_en;
    assign ent_en = wr_en && (wr_addr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q[g] <= '0;
      else if (ent_en) ent_q[g] <= wr_data;
    end
  end

  assign rd_data = ent_q[rd_addr];
endmodule

// File: rtl/codec_ctl_writer.sv
module codec_ctl_writer #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 9,
  parameter int STEP_CYCLES = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_nocache,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              ser_clk,
  output logic              ser_dat,
  output logic              sel_n,
  output logic              dir_wr
);
  localparam int FRAME_W = ADDR_W + DATA_W;

  logic busy, accept, step_done;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  ccw_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(accept), .run(busy),
    .step_done(step_done)
  );

  ccw_sequencer #(.FRAME_W(FRAME_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept),
    .frame_in({req_addr, req_data}), .step_done(step_done),
    .busy(busy), .sclk(ser_clk), .sdo(ser_dat), .csn(sel_n), .rw(dir_wr)
  );

  ccw_shadow #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(accept && !req_nocache),
    .wr_addr(req_addr), .wr_data(req_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/codec_ctl_writer_chk.sv
module codec_ctl_writer_chk #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_data,
  input logic              req_nocache,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              ser_clk,
  input logic              ser_dat,
  input logic              sel_n,
  input logic              dir_wr
);
  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sel_n && ser_clk && !dir_wr));
  // R3
  start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!sel_n && dir_wr));
  // R4
  data_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_dat) |-> !ser_clk);
  // R5
  end_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_n) |-> $fell(ser_clk));
  // R6
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R7
  cache_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_nocache && rd_addr == req_addr) |=>
      (rd_addr != $past(rd_addr)) || (rd_data == $past(req_data)));
  // R8
  nocache_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_nocache) |=>
      (!$stable(rd_addr) || $stable(rd_data)));
endmodule

bind codec_ctl_writer codec_ctl_writer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_data(req_data), .req_nocache(req_nocache),
  .rd_addr(rd_addr), .rd_data(rd_data), .ser_clk(ser_clk), .ser_dat(ser_dat),
  .sel_n(sel_n), .dir_wr(dir_wr)
);

// File: tb/codec_ctl_writer_tb.sv
module codec_ctl_writer_tb;
  localparam int STEP = 3;

  logic clk, rst_n, req_valid, req_ready, req_nocache;
  logic [6:0] req_addr, rd_addr;
  logic [8:0] req_data, rd_data;
  logic ser_clk, ser_dat, sel_n, dir_wr;

  int errors = 0, checks = 0, cyc = 0;
  logic [8:0] model [128];

  // frame monitor state
  logic [15:0] mon_sh;
  int mon_bits, t_fall, t_rise, t_csn, t_trail;
  logic mon_rw, fall_seen, rise_seen, trail_pend;

  codec_ctl_writer #(.STEP_CYCLES(STEP)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_nocache(req_nocache),
    .rd_addr(rd_addr), .rd_data(rd_data), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .sel_n(sel_n), .dir_wr(dir_wr)
  );

  initial begin clk = 1'b0; forever #5 clk = ~clk; end
  always @(negedge clk) cyc <= cyc + 1;

  always @(negedge sel_n) begin
    mon_bits = 0; mon_sh = '0; mon_rw = dir_wr; fall_seen = 1'b0; rise_seen = 1'b0;
  end
  always @(negedge ser_clk) if (!sel_n && !fall_seen) begin
    fall_seen = 1'b1; t_fall = cyc;
  end
  always @(posedge ser_clk) begin
    if (!sel_n) begin
      mon_sh = {mon_sh[14:0], ser_dat}; mon_bits++;
      if (!rise_seen) begin rise_seen = 1'b1; t_rise = cyc; end
    end else if (trail_pend) begin
      trail_pend = 1'b0; t_trail = cyc;
    end
  end
  always @(posedge sel_n) begin t_csn = cyc; trail_pend = 1'b1; end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [6:0] a, input logic [8:0] d, input logic nc,
                          input logic poke_busy);
    int t_acc, n;
    @(negedge clk);
    trail_pend = 1'b0; t_trail = -1; t_csn = -1;
    req_addr = a; req_data = d; req_nocache = nc; req_valid = 1'b1;
    @(posedge clk); t_acc = cyc;
    @(negedge clk); req_valid = 1'b0; n = 1;
    if (poke_busy) begin
      // R10: request while busy, other address and data
      req_addr = a ^ 7'h55; req_data = ~d; req_nocache = 1'b0; req_valid = 1'b1;
      repeat (5) begin @(negedge clk); n++; end
      req_valid = 1'b0;
    end
    while (!req_ready) begin @(negedge clk); n++; end
    chk("R6 busy length", n - 1, 51 * STEP);
    chk("R2 frame", int'(mon_sh), int'({a, d}));
    chk("R2 bit count", mon_bits, 16);
    chk("R3 dir_wr at select", int'(mon_rw), 1);
    chk("R3 first fall", t_fall - t_acc, STEP);
    chk("R4 first rise", t_rise - t_acc, 3 * STEP);
    chk("R5 select release", t_csn - t_acc, 49 * STEP);
    chk("R5 trailing rise", t_trail - t_acc, 50 * STEP);
    if (!nc) model[a] = d;
  endtask

  task automatic check_shadow(input string req);
    for (int i = 0; i < 128; i++) begin
      rd_addr = 7'(i); #1;
      chk(req, int'(rd_data), int'(model[i]));
    end
  endtask

  initial begin
    int wd;
    wd = 0;
    fork
      begin
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_data = '0;
        req_nocache = 1'b0; rd_addr = '0;
        for (int i = 0; i < 128; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 sel_n", int'(sel_n), 1);
        chk("R1 ser_clk", int'(ser_clk), 1);
        chk("R1 dir_wr", int'(dir_wr), 0);
        chk("R1 ready", int'(req_ready), 1);
        check_shadow("R1 shadow zero");
        // R2 R7 sweep of every address
        for (int a = 0; a < 128; a++) begin
          do_write(7'(a), 9'((a * 37 + 5) & 511), 1'b0, 1'b0);
          rd_addr = 7'(a); #1;
          chk("R7 store", int'(rd_data), int'(model[a]));
        end
        check_shadow("R9 readback sweep");
        // R2 boundary values
        do_write(7'd127, 9'h1FF, 1'b0, 1'b0);
        do_write(7'd0, 9'h000, 1'b0, 1'b0);
        do_write(7'd127, 9'h000, 1'b0, 1'b0);
        do_write(7'd0, 9'h1FF, 1'b0, 1'b0);
        // R8 no-cache writes
        for (int k = 0; k < 8; k++)
          do_write(7'(k * 16 + 3), 9'(k * 61 + 100), 1'b1, 1'b0);
        check_shadow("R8 shadow kept");
        // R10 request while busy
        do_write(7'd10, 9'h0AA, 1'b0, 1'b1);
        do_write(7'd90, 9'h133, 1'b1, 1'b1);
        check_shadow("R10 busy request ignored");
      end
      begin
        while (wd < 150000) begin @(negedge clk); wd++; end
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule